// File: doc/BRIEF.md
# Interrupting Device Acknowledge Responder

This block sits inside a peripheral and handles the device side of a processor interrupt. When an event arrives it raises an interrupt request at a configured priority level from 1 to 7. It then watches the bus for the processor's interrupt acknowledge cycle. That cycle is a read in CPU space whose cycle type field marks it as an acknowledge, and it carries the level being acknowledged on three address bits. When the cycle is for the device's own level and the device has a request pending, the block answers in one of two ways, chosen by configuration.

In vectored operation the block drives its 8-bit vector on the lowest-order byte lane of its data port. Which lane that is depends on how wide the port is. It terminates the cycle with either an asynchronous size acknowledge or a one-clock synchronous termination. In autovector operation it drives no data. It asserts only the autovector signal and leaves both other terminations idle. When the processor negates the address strobe, the block drops everything it drives. Accepting an acknowledge clears the request, and a later event arms it again.

Top module: `int_ack_responder`

## Requirements
- R1: While reset is asserted and after it is released, irq_level is 0, lane_oe is all zeros, data_o is 0, size_ack is 2'b00, and sync_term and autovec are low.
- R2: An irq_event pulse with cfg_level in 1..7 makes irq_level equal cfg_level from the following clock. An event while cfg_level is 0 is ignored and irq_level stays 0.
- R3: A cycle is accepted only when all of the following hold at a clock edge: a request is pending, bus_rw=1 (read), bus_fc=3'b111 (CPU space), bus_addr[19:16]=4'hF (acknowledge type), bus_addr[3:1] equals cfg_level, bus_size=2'b01 (byte), and bus_as_n and bus_ds_n are both low. The response appears from the next clock.
- R4: In vectored mode with asynchronous termination, only lane_oe bit (DATA_W-PORT_W)/8 is set, and that byte of data_o holds cfg_vector as latched at acceptance. size_ack is 2'b01 for an 8-bit port, 2'b10 for a 16-bit port and 2'b11 for a 32-bit port.
- R5: In vectored mode with cfg_sync_term=1, sync_term is high for exactly one clock per accepted cycle and size_ack stays 2'b00, while the vector lane stays driven.
- R6: In autovector mode (cfg_autovec=1), autovec is high while answering, and size_ack, sync_term and lane_oe all stay zero.
- R7: The pending request is cleared at acceptance, so irq_level is 0 in the first clock of the response.
- R8: The response is held while bus_as_n stays low. One clock after bus_as_n is sampled high, lane_oe, data_o, size_ack, sync_term and autovec are all zero.
- R9: Writes, other function codes, other cycle types and acknowledges for other levels are ignored: no output is driven and irq_level keeps its value.
- R10: An irq_event in the same clock as acceptance leaves the request pending. An event after acceptance raises the request again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| irq_event | input | 1 | One-clock pulse that arms the interrupt request |
| cfg_level | input | 3 | Request priority level, 0 disables |
| cfg_vector | input | 8 | Vector number supplied in vectored mode |
| cfg_autovec | input | 1 | 1 selects autovector answer |
| cfg_sync_term | input | 1 | 1 selects synchronous termination in vectored mode |
| irq_level | output | 3 | Encoded request level, 0 when idle |
| bus_fc | input | 3 | Function code |
| bus_addr | input | ADDR_W | Address bus |
| bus_rw | input | 1 | 1 for read |
| bus_size | input | 2 | Transfer size, 2'b01 is byte |
| bus_as_n | input | 1 | Address strobe, active low |
| bus_ds_n | input | 1 | Data strobe, active low |
| data_o | output | DATA_W | Data driven toward the bus |
| lane_oe | output | DATA_W/8 | Per-byte-lane output enable, 0 means released |
| size_ack | output | 2 | Size acknowledge code, active high |
| sync_term | output | 1 | Synchronous termination, active high |
| autovec | output | 1 | Autovector request, active high |

## Verification
The bench builds the block with a 32-bit data bus, a 16-bit port and a 32-bit address. This places the vector on byte lane 2, which is neither the bottom nor the top lane, and gives the 16-bit size acknowledge code. With those values a wrong lane index or a wrong size code shows up at the ports. The bench switches termination mode and level between runs, so all three answer styles are tested. Decode mismatches are tested one field at a time, and an event is made to land in the same clock as acceptance.

// File: rtl/int_resp_pkg.sv
package int_resp_pkg;

  typedef enum logic {
    ST_IDLE   = 1'b0,
    ST_ANSWER = 1'b1
  } resp_state_e;

  localparam logic [2:0] FC_CPU_SPACE = 3'b111;
  localparam logic [3:0] TYPE_IACK    = 4'hF;
  localparam logic [1:0] SIZE_BYTE    = 2'b01;

  function automatic logic [1:0] port_size_code(input int port_w);
    if (port_w == 8)       return 2'b01;
    else if (port_w == 16) return 2'b10;
    else                   return 2'b11;
  endfunction

endpackage

// File: rtl/irq_pending.sv
module irq_pending (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       arm,
  input  logic [2:0] level,
  input  logic       accept,
  output logic       pend,
  output logic [2:0] irq_level
);

  logic pend_q;
  logic pend_d;
  logic pend_en;

  always_comb begin
    pend_en = 1'b0;
    pend_d  = pend_q;
    if (arm && (level != 3'd0)) begin
      pend_en = 1'b1;
      pend_d  = 1'b1;
    end else if (accept) begin
      pend_en = 1'b1;
      pend_d  = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
    end else if (pend_en) begin
      pend_q <= pend_d;
    end
  end

  assign pend      = pend_q;
  assign irq_level = pend_q ? level : 3'd0;

endmodule

// File: rtl/iack_decode.sv
module iack_decode #(
  parameter int ADDR_W = 32
) (
  input  logic [2:0]        fc,
  input  logic [ADDR_W-1:0] addr,
  input  logic              rw,
  input  logic [1:0]        size,
  input  logic              as_n,
  input  logic              ds_n,
  input  logic [2:0]        level,
  input  logic              pend,
  output logic              hit
);
  import int_resp_pkg::*;

  logic strobes_on;
  logic space_ok;
  logic type_ok;
  logic level_ok;

  always_comb begin
    strobes_on = !as_n && !ds_n;
    space_ok   = rw && (fc == FC_CPU_SPACE) && (size == SIZE_BYTE);
    type_ok    = (addr[19:16] == TYPE_IACK);
    level_ok   = (addr[3:1] == level) && (level != 3'd0);
    hit        = pend && strobes_on && space_ok && type_ok && level_ok;
  end

endmodule

// File: rtl/ack_sequencer.sv
module ack_sequencer #(
  parameter int DATA_W = 32,
  parameter int PORT_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hit,
  input  logic              as_n,
  input  logic [7:0]        vector,
  input  logic              use_autovec,
  input  logic              use_sync,
  output logic              accept,
  output logic [DATA_W-1:0] data_o,
  output logic [DATA_W/8-1:0] lane_oe,
  output logic [1:0]        size_ack,
  output logic              sync_term,
  output logic              autovec
);
  import int_resp_pkg::*;

  localparam int         LANES     = DATA_W / 8;
  localparam int         VEC_LANE  = (DATA_W - PORT_W) / 8;
  localparam logic [1:0] SIZE_CODE = port_size_code(PORT_W);

  resp_state_e state_q, state_d;
  logic        drive_q, drive_d;
  logic [7:0]  vec_q, vec_d;
  logic [1:0]  size_q, size_d;
  logic        sync_q, sync_d;
  logic        avec_q, avec_d;

  always_comb begin
    state_d = state_q;
    drive_d = drive_q;
    vec_d   = vec_q;
    size_d  = size_q;
    sync_d  = sync_q;
    avec_d  = avec_q;
    accept  = 1'b0;
    case (state_q)
      ST_IDLE: begin
        if (hit) begin
          accept  = 1'b1;
          state_d = ST_ANSWER;
          vec_d   = vector;
          if (use_autovec) begin
            avec_d = 1'b1;
          end else begin
            drive_d = 1'b1;
            if (use_sync) sync_d = 1'b1;
            else          size_d = SIZE_CODE;
          end
        end
      end
      ST_ANSWER: begin
        sync_d = 1'b0;
        if (as_n) begin
          state_d = ST_IDLE;
          drive_d = 1'b0;
          size_d  = 2'b00;
          avec_d  = 1'b0;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      drive_q <= 1'b0;
      vec_q   <= 8'h00;
      size_q  <= 2'b00;
      sync_q  <= 1'b0;
      avec_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      drive_q <= drive_d;
      vec_q   <= vec_d;
      size_q  <= size_d;
      sync_q  <= sync_d;
      avec_q  <= avec_d;
    end
  end

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    if (g == VEC_LANE) begin : g_vec
      assign lane_oe[g]         = drive_q;
      assign data_o[8*g +: 8]   = drive_q ? vec_q : 8'h00;
    end else begin : g_idle
      assign lane_oe[g]         = 1'b0;
      assign data_o[8*g +: 8]   = 8'h00;
    end
  end

  assign size_ack  = size_q;
  assign sync_term = sync_q;
  assign autovec   = avec_q;

endmodule

// File: rtl/int_ack_responder.sv
module int_ack_responder #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int PORT_W = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                irq_event,
  input  logic [2:0]          cfg_level,
  input  logic [7:0]          cfg_vector,
  input  logic                cfg_autovec,
  input  logic                cfg_sync_term,
  output logic [2:0]          irq_level,
  input  logic [2:0]          bus_fc,
  input  logic [ADDR_W-1:0]   bus_addr,
  input  logic                bus_rw,
  input  logic [1:0]          bus_size,
  input  logic                bus_as_n,
  input  logic                bus_ds_n,
  output logic [DATA_W-1:0]   data_o,
  output logic [DATA_W/8-1:0] lane_oe,
  output logic [1:0]          size_ack,
  output logic                sync_term,
  output logic                autovec
);

  logic rst_s1_q, rst_s2_q;
  logic rst_int_n;
  logic pend;
  logic hit;
  logic accept;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_s1_q <= 1'b0;
      rst_s2_q <= 1'b0;
    end else begin
      rst_s1_q <= 1'b1;
      rst_s2_q <= rst_s1_q;
    end
  end
  assign rst_int_n = rst_s2_q;

  irq_pending u_pend (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .arm       (irq_event),
    .level     (cfg_level),
    .accept    (accept),
    .pend      (pend),
    .irq_level (irq_level)
  );

  iack_decode #(.ADDR_W(ADDR_W)) u_dec (
    .fc    (bus_fc),
    .addr  (bus_addr),
    .rw    (bus_rw),
    .size  (bus_size),
    .as_n  (bus_as_n),
    .ds_n  (bus_ds_n),
    .level (cfg_level),
    .pend  (pend),
    .hit   (hit)
  );

  ack_sequencer #(.DATA_W(DATA_W), .PORT_W(PORT_W)) u_seq (
    .clk         (clk),
    .rst_n       (rst_int_n),
    .hit         (hit),
    .as_n        (bus_as_n),
    .vector      (cfg_vector),
    .use_autovec (cfg_autovec),
    .use_sync    (cfg_sync_term),
    .accept      (accept),
    .data_o      (data_o),
    .lane_oe     (lane_oe),
    .size_ack    (size_ack),
    .sync_term   (sync_term),
    .autovec     (autovec)
  );

endmodule

// File: rtl/int_ack_responder_chk.sv
module int_ack_responder_chk #(
  parameter int LANES = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             irq_event,
  input logic [2:0]       irq_level,
  input logic             bus_as_n,
  input logic [LANES-1:0] lane_oe,
  input logic [1:0]       size_ack,
  input logic             sync_term,
  input logic             autovec
);

  p_avec_alone_r6: assert property (@(posedge clk) disable iff (!rst_n)
    autovec |-> (size_ack == 2'b00 && !sync_term && lane_oe == '0));

  p_sync_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
    sync_term |=> !sync_term);

  p_sync_no_size_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !(sync_term && size_ack != 2'b00));

  p_one_lane_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(lane_oe));

  p_release_r8: assert property (@(posedge clk) disable iff (!rst_n)
    bus_as_n |=> (lane_oe == '0 && size_ack == 2'b00 && !sync_term && !autovec));

  p_req_cleared_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(sync_term || autovec || size_ack != 2'b00) && !$past(irq_event))
      |-> irq_level == 3'd0);

endmodule

bind int_ack_responder int_ack_responder_chk #(.LANES(DATA_W/8)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .irq_event (irq_event),
  .irq_level (irq_level),
  .bus_as_n  (bus_as_n),
  .lane_oe   (lane_oe),
  .size_ack  (size_ack),
  .sync_term (sync_term),
  .autovec   (autovec)
);

// File: tb/int_ack_responder_tb.sv
module int_ack_responder_tb;

  localparam int ADDR_W = 32;
  localparam int DATA_W = 32;
  localparam int PORT_W = 16;
  localparam int LANES  = DATA_W / 8;
  localparam int VLANE  = 2;

  logic              clk = 1'b0;
  logic              rst_n;
  logic              irq_event;
  logic [2:0]        cfg_level;
  logic [7:0]        cfg_vector;
  logic              cfg_autovec, cfg_sync_term;
  logic [2:0]        irq_level;
  logic [2:0]        bus_fc;
  logic [ADDR_W-1:0] bus_addr;
  logic              bus_rw;
  logic [1:0]        bus_size;
  logic              bus_as_n, bus_ds_n;
  logic [DATA_W-1:0] data_o;
  logic [LANES-1:0]  lane_oe;
  logic [1:0]        size_ack;
  logic              sync_term, autovec;

  int compared = 0;
  int mismatched = 0;
  int cyc = 0;
  int sync_cnt = 0;
  int resp_cnt = 0;

  always #10 clk = ~clk;

  int_ack_responder #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .PORT_W(PORT_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .irq_event(irq_event), .cfg_level(cfg_level),
    .cfg_vector(cfg_vector), .cfg_autovec(cfg_autovec), .cfg_sync_term(cfg_sync_term),
    .irq_level(irq_level), .bus_fc(bus_fc), .bus_addr(bus_addr), .bus_rw(bus_rw),
    .bus_size(bus_size), .bus_as_n(bus_as_n), .bus_ds_n(bus_ds_n), .data_o(data_o),
    .lane_oe(lane_oe), .size_ack(size_ack), .sync_term(sync_term), .autovec(autovec)
  );

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s: actual %0h expected %0h at cycle %0d", tag, act, exp, cyc);
    end
  endtask

  // behavioural reference model
  int  rel = 0;
  bit  m_pend, m_busy, m_oe, m_sync, m_avec;
  logic [7:0] m_vec;
  logic [1:0] m_size;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rel = 0; m_pend = 0; m_busy = 0; m_oe = 0; m_sync = 0; m_avec = 0;
      m_vec = 0; m_size = 0;
    end else if (rel < 2) begin
      rel++;
    end else begin
      bit match, acc;
      match = m_pend && !bus_as_n && !bus_ds_n && bus_rw && bus_fc == 3'd7 &&
              bus_addr[19:16] == 4'hF && bus_addr[3:1] == cfg_level &&
              cfg_level != 0 && bus_size == 2'b01;
      acc = !m_busy && match;
      if (acc) begin
        m_busy = 1; m_vec = cfg_vector;
        if (cfg_autovec) m_avec = 1;
        else begin
          m_oe = 1;
          if (cfg_sync_term) m_sync = 1; else m_size = 2'b10;
        end
      end else if (m_busy) begin
        m_sync = 0;
        if (bus_as_n) begin
          m_busy = 0; m_oe = 0; m_size = 0; m_avec = 0;
        end
      end
      if (irq_event && cfg_level != 0) m_pend = 1;
      else if (acc) m_pend = 0;
    end
  end

  // compare every clock, away from the edge
  always @(posedge clk) begin
    #5;
    cyc++;
    if (rst_n) begin
      logic [2:0] e_lvl;
      logic [LANES-1:0] e_oe;
      logic [DATA_W-1:0] e_data;
      e_lvl  = m_pend ? cfg_level : 3'd0;
      e_oe   = m_oe ? LANES'(1 << VLANE) : '0;
      e_data = m_oe ? (DATA_W'(m_vec) << (8 * VLANE)) : '0;
      check(irq_level == e_lvl, "R2/R7 irq_level", irq_level, e_lvl);
      check(lane_oe == e_oe, "R4 lane_oe", lane_oe, e_oe);
      check(data_o == e_data, "R4 data_o", data_o, e_data);
      check(size_ack == m_size, "R4 size_ack", size_ack, m_size);
      check(sync_term == m_sync, "R5 sync_term", sync_term, m_sync);
      check(autovec == m_avec, "R6 autovec", autovec, m_avec);
      if (sync_term) sync_cnt++;
      if (sync_term || autovec || size_ack != 0) resp_cnt++;
    end
    if (cyc > 20000) begin
      mismatched++;
      $display("FAIL watchdog: actual %0d expected below 20000 cycles", cyc);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  task automatic pulse_event();
    @(negedge clk); irq_event = 1'b1;
    @(negedge clk); irq_event = 1'b0;
  endtask

  task automatic run_cycle(input logic [2:0] lvl, input logic [2:0] fc, input logic [3:0] typ,
                           input logic rw, input int hold, input bit evt);
    @(negedge clk);
    bus_fc = fc; bus_addr = {12'h0, typ, 12'h0, lvl, 1'b0}; bus_rw = rw;
    bus_size = 2'b01; bus_as_n = 1'b0; bus_ds_n = 1'b0; irq_event = evt;
    @(negedge clk); irq_event = 1'b0;
    repeat (hold - 1) @(negedge clk);
    bus_as_n = 1'b1; bus_ds_n = 1'b1; bus_rw = 1'b1; bus_fc = 3'd0;
    repeat (2) @(negedge clk);
  endtask

  task automatic check_idle(input string tag);
    check(lane_oe == 0 && size_ack == 0 && !sync_term && !autovec && data_o == 0,
          tag, {lane_oe, size_ack, sync_term, autovec}, 0);
  endtask

  initial begin
    int r0;
    rst_n = 0; irq_event = 0; cfg_level = 0; cfg_vector = 0; cfg_autovec = 0;
    cfg_sync_term = 0; bus_fc = 0; bus_addr = 0; bus_rw = 1; bus_size = 0;
    bus_as_n = 1; bus_ds_n = 1;
    repeat (3) @(negedge clk);
    check(irq_level == 0, "R1 reset irq_level", irq_level, 0);
    check_idle("R1 reset outputs");
    rst_n = 1;
    repeat (4) @(negedge clk);
    check_idle("R1 after release");

    // R2: level 0 ignores events
    pulse_event();
    check(irq_level == 0, "R2 level zero ignored", irq_level, 0);

    // vectored, size acknowledge, level 5
    cfg_level = 3'd5; cfg_vector = 8'h42;
    pulse_event();
    check(irq_level == 3'd5, "R2 request level", irq_level, 5);
    r0 = resp_cnt;
    run_cycle(3'd5, 3'd7, 4'hF, 1'b1, 4, 1'b0);
    check(resp_cnt - r0 == 4, "R3 R8 response held while strobe low", resp_cnt - r0, 4);
    check(irq_level == 0, "R7 request cleared", irq_level, 0);
    check_idle("R8 released");

    // R9: non-matching cycles with level 3 pending
    cfg_level = 3'd3; cfg_vector = 8'hA5;
    pulse_event();
    r0 = resp_cnt;
    run_cycle(3'd4, 3'd7, 4'hF, 1'b1, 3, 1'b0);
    run_cycle(3'd3, 3'd7, 4'h0, 1'b1, 3, 1'b0);
    run_cycle(3'd3, 3'd7, 4'hF, 1'b0, 3, 1'b0);
    run_cycle(3'd3, 3'd5, 4'hF, 1'b1, 3, 1'b0);
    check(resp_cnt == r0, "R9 no response to others", resp_cnt - r0, 0);
    check(irq_level == 3'd3, "R9 request kept", irq_level, 3);

    // R5: synchronous termination
    cfg_sync_term = 1'b1;
    r0 = sync_cnt;
    run_cycle(3'd3, 3'd7, 4'hF, 1'b1, 5, 1'b0);
    check(sync_cnt - r0 == 1, "R5 one-clock termination", sync_cnt - r0, 1);
    check_idle("R8 released after sync");
    cfg_sync_term = 1'b0;

    // R6: autovector at level 7
    cfg_level = 3'd7; cfg_autovec = 1'b1;
    pulse_event();
    r0 = resp_cnt;
    run_cycle(3'd7, 3'd7, 4'hF, 1'b1, 3, 1'b0);
    check(resp_cnt - r0 == 3, "R6 autovector held", resp_cnt - r0, 3);
    check(irq_level == 0, "R7 cleared after autovector", irq_level, 0);
    cfg_autovec = 1'b0;

    // R10: event together with acceptance, then re-arm
    cfg_level = 3'd1; cfg_vector = 8'h3C;
    pulse_event();
    run_cycle(3'd1, 3'd7, 4'hF, 1'b1, 2, 1'b1);
    check(irq_level == 3'd1, "R10 event at accept keeps request", irq_level, 1);
    run_cycle(3'd1, 3'd7, 4'hF, 1'b1, 2, 1'b0);
    check(irq_level == 0, "R10 cleared by second accept", irq_level, 0);
    pulse_event();
    check(irq_level == 3'd1, "R10 re-armed", irq_level, 1);

    repeat (3) @(negedge clk);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

endmodule